// File: doc/BRIEF.md
# SD Host Interrupt Status Bank

This block keeps the interrupt state of an SD host controller. It has two status registers and a mask register for each. Single-cycle event pulses come from the command, data-path and card-detect logic, and each one sets a sticky bit. Three bits of the status registers are not stored: they show the current level of the card-detect input, the DAT0 line and the command-busy signal. The two buffer-ready flags are set on the rising edge of a level input. A flag therefore appears once per block, and it does not come back while the buffer stays ready.

Software reaches the four registers through a small register port. A read returns the selected register at once. Writing a zero to an event bit clears that bit, and writing a one leaves it as it is. A single interrupt line is high while any event bit is set and its mask bit is clear. Software must clear a buffer-ready flag before it drains or fills the buffer. If it does not, the next block's edge may be lost.

Top module: `sdirq_status_bank`

## Requirements
- R1: After reset, every event bit reads 0, each mask register reads back all of its event positions as 1 (everything masked), and `irq` is low.
- R2: In status register 1 (address 0), a one-cycle pulse sets a sticky bit: response done at bit 0, data done at bit 2, card removed at bit 3, card inserted at bit 4.
- R3: Status register 1 bit 5 always reads the present level of `card_present`, and writes to it have no effect.
- R4: In status register 2 (address 1), a one-cycle pulse sets a sticky bit: command index error at bit 0, CRC error at bit 1, end-bit error at bit 2, data timeout at bit 3, illegal write at bit 4, illegal read at bit 5, response timeout at bit 6, illegal access at bit 15.
- R5: Status register 2 bit 7 reads `dat0_lvl` and bit 14 reads `cmd_busy` as live levels, and writes to them have no effect.
- R6: Status register 2 bit 8 (read buffer ready) and bit 9 (write buffer ready) are set only on a 0-to-1 change of `rd_buf_rdy` or `wr_buf_rdy`. Once cleared, a bit stays clear while its level remains high.
- R7: A write to a status register clears every event bit written as 0 and leaves every event bit written as 1 unchanged.
- R8: If an event pulse and a write of 0 reach the same bit in the same cycle, the bit ends up set.
- R9: Address 2 is mask register 1 and address 3 is mask register 2. A mask bit set to 1 masks its event. Only event positions are stored, so mask 1 reads back within 0x001D and mask 2 within 0x837F.
- R10: `irq` is high exactly when some event bit is 1 and its mask bit is 0.
- R11: Bits with no function read 0: bits 1 and 6 to 15 of status register 1, and bits 10 to 13 of status register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_done_p | input | 1 | Response complete pulse |
| data_done_p | input | 1 | Data transfer complete pulse |
| card_removed_p | input | 1 | Card removal pulse |
| card_inserted_p | input | 1 | Card insertion pulse |
| cmd_idx_err_p | input | 1 | Command index error pulse |
| crc_err_p | input | 1 | CRC error pulse |
| end_bit_err_p | input | 1 | End-bit error pulse |
| data_tmo_p | input | 1 | Data timeout pulse |
| ill_wr_p | input | 1 | Illegal write pulse |
| ill_rd_p | input | 1 | Illegal read pulse |
| rsp_tmo_p | input | 1 | Response timeout pulse |
| ill_acc_p | input | 1 | Illegal access pulse |
| rd_buf_rdy | input | 1 | Level: read buffer holds a full block |
| wr_buf_rdy | input | 1 | Level: write buffer can take a block |
| card_present | input | 1 | Live card-detect level |
| dat0_lvl | input | 1 | Live DAT0 line level |
| cmd_busy | input | 1 | Live command-busy level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status 1, 1 status 2, 2 mask 1, 3 mask 2 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a buffer-ready flag cleared while its level stays high. No new edge may then set the flag again, and the flag must return only after the level falls and rises. The bench holds the ready levels high across several clearing writes and idle cycles before it toggles them. A second hard case is an event pulse in the same cycle as a clearing write to its own register. The bench issues both in one cycle, on purpose and also during a long pseudo-random sweep. That sweep mixes pulses, level edges, clears and mask changes, and it compares every register and the interrupt line against an arithmetic model after every cycle.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NBANK  = 2;

  // status register 1 bit positions
  localparam int unsigned S1_RSP_DONE  = 0;
  localparam int unsigned S1_DATA_DONE = 2;
  localparam int unsigned S1_CARD_RM   = 3;
  localparam int unsigned S1_CARD_IN   = 4;
  localparam int unsigned S1_CARD_LVL  = 5;

  // status register 2 bit positions
  localparam int unsigned S2_IDX_ERR   = 0;
  localparam int unsigned S2_CRC_ERR   = 1;
  localparam int unsigned S2_END_ERR   = 2;
  localparam int unsigned S2_DATA_TMO  = 3;
  localparam int unsigned S2_ILL_WR    = 4;
  localparam int unsigned S2_ILL_RD    = 5;
  localparam int unsigned S2_RSP_TMO   = 6;
  localparam int unsigned S2_DAT0_LVL  = 7;
  localparam int unsigned S2_RD_RDY    = 8;
  localparam int unsigned S2_WR_RDY    = 9;
  localparam int unsigned S2_BUSY_LVL  = 14;
  localparam int unsigned S2_ILL_ACC   = 15;

  // positions that hold sticky events
  localparam logic [REG_W-1:0] EVT1_BITS =
    (REG_W'(1) << S1_RSP_DONE) | (REG_W'(1) << S1_DATA_DONE) |
    (REG_W'(1) << S1_CARD_RM)  | (REG_W'(1) << S1_CARD_IN);

  localparam logic [REG_W-1:0] EVT2_BITS =
    (REG_W'(1) << S2_IDX_ERR)  | (REG_W'(1) << S2_CRC_ERR)  |
    (REG_W'(1) << S2_END_ERR)  | (REG_W'(1) << S2_DATA_TMO) |
    (REG_W'(1) << S2_ILL_WR)   | (REG_W'(1) << S2_ILL_RD)   |
    (REG_W'(1) << S2_RSP_TMO)  | (REG_W'(1) << S2_RD_RDY)   |
    (REG_W'(1) << S2_WR_RDY)   | (REG_W'(1) << S2_ILL_ACC);

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT1 = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_MASK1 = 2'd2,
    SEL_MASK2 = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] bank_evt_bits(input int unsigned bank);
    return (bank == 0) ? EVT1_BITS : EVT2_BITS;
  endfunction

endpackage

// File: rtl/sdirq_edge_det.sv
module sdirq_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic         prev_en;

  always_comb begin
    prev_d  = lvl;
    prev_en = (lvl != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  assign rise = lvl & ~prev_q;

  // R6: a level held high for two cycles never produces a second edge
  p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == $past(lvl)) |-> ((rise & $past(lvl)) == '0));

endmodule

// File: rtl/sdirq_evt_reg.sv
module sdirq_evt_reg #(
  parameter int unsigned          W   = 16,
  parameter logic [W-1:0]         EVT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] keep;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    keep = wr_en ? wdata : '1;
    q_d  = ((q & keep) | set) & EVT;
    q_en = wr_en | (|(set & EVT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  // R8: a pulse always lands, whatever the write did in that cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set & EVT)) |=> ((q & $past(set & EVT)) == $past(set & EVT)));

  // R7: bits written as zero without a pulse read back cleared
  p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set == '0) |=> ((q & ~$past(wdata)) == '0));

  // R7: a one written to a set bit keeps it set
  p_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(q & wdata)) == $past(q & wdata)));

  // R2: nothing moves without a write or a pulse
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set == '0) |=> $stable(q));

endmodule

// File: rtl/sdirq_mask_reg.sv
module sdirq_mask_reg #(
  parameter int unsigned  W   = 16,
  parameter logic [W-1:0] EVT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = wdata & EVT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= EVT;
    end else if (wr_en) begin
      q <= q_d;
    end
  end

  // R9: a mask holds its value between writes
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/sdirq_status_bank.sv
module sdirq_status_bank
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_done_p,
  input  logic              data_done_p,
  input  logic              card_removed_p,
  input  logic              card_inserted_p,
  input  logic              cmd_idx_err_p,
  input  logic              crc_err_p,
  input  logic              end_bit_err_p,
  input  logic              data_tmo_p,
  input  logic              ill_wr_p,
  input  logic              ill_rd_p,
  input  logic              rsp_tmo_p,
  input  logic              ill_acc_p,
  input  logic              rd_buf_rdy,
  input  logic              wr_buf_rdy,
  input  logic              card_present,
  input  logic              dat0_lvl,
  input  logic              cmd_busy,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);

  logic [1:0]       buf_rise;
  logic [REG_W-1:0] bank_set  [NBANK];
  logic [REG_W-1:0] bank_stat [NBANK];
  logic [REG_W-1:0] bank_mask [NBANK];
  logic [REG_W-1:0] bank_live [NBANK];
  logic [NBANK-1:0] bank_pend;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  sdirq_edge_det #(.W(2)) i_buf_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({wr_buf_rdy, rd_buf_rdy}),
    .rise  (buf_rise)
  );

  always_comb begin
    bank_set[0] = '0;
    bank_set[0][S1_RSP_DONE]  = rsp_done_p;
    bank_set[0][S1_DATA_DONE] = data_done_p;
    bank_set[0][S1_CARD_RM]   = card_removed_p;
    bank_set[0][S1_CARD_IN]   = card_inserted_p;

    bank_set[1] = '0;
    bank_set[1][S2_IDX_ERR]   = cmd_idx_err_p;
    bank_set[1][S2_CRC_ERR]   = crc_err_p;
    bank_set[1][S2_END_ERR]   = end_bit_err_p;
    bank_set[1][S2_DATA_TMO]  = data_tmo_p;
    bank_set[1][S2_ILL_WR]    = ill_wr_p;
    bank_set[1][S2_ILL_RD]    = ill_rd_p;
    bank_set[1][S2_RSP_TMO]   = rsp_tmo_p;
    bank_set[1][S2_RD_RDY]    = buf_rise[0];
    bank_set[1][S2_WR_RDY]    = buf_rise[1];
    bank_set[1][S2_ILL_ACC]   = ill_acc_p;

    bank_live[0] = '0;
    bank_live[0][S1_CARD_LVL] = card_present;
    bank_live[1] = '0;
    bank_live[1][S2_DAT0_LVL] = dat0_lvl;
    bank_live[1][S2_BUSY_LVL] = cmd_busy;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [REG_W-1:0] EVT = bank_evt_bits(g);
    logic stat_we;
    logic mask_we;

    assign stat_we = reg_we && (reg_addr == ADDR_W'(g));
    assign mask_we = reg_we && (reg_addr == ADDR_W'(g + NBANK));

    sdirq_evt_reg #(.W(REG_W), .EVT(EVT)) i_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (bank_set[g]),
      .wr_en (stat_we),
      .wdata (reg_wdata),
      .q     (bank_stat[g])
    );

    sdirq_mask_reg #(.W(REG_W), .EVT(EVT)) i_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mask_we),
      .wdata (reg_wdata),
      .q     (bank_mask[g])
    );

    assign bank_pend[g] = |(bank_stat[g] & ~bank_mask[g]);
  end

  always_comb begin
    unique case (sel)
      SEL_STAT1: reg_rdata = bank_stat[0] | bank_live[0];
      SEL_STAT2: reg_rdata = bank_stat[1] | bank_live[1];
      SEL_MASK1: reg_rdata = bank_mask[0];
      SEL_MASK2: reg_rdata = bank_mask[1];
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |bank_pend;

  // R10: with every event masked the line stays low
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mask[0] == EVT1_BITS && bank_mask[1] == EVT2_BITS) |-> !irq);

  // R10: no stored event means no interrupt
  p_irq_needs_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_stat[0] == '0 && bank_stat[1] == '0) |-> !irq);

  // R3: the card-detect bit of a status read follows the pin
  p_card_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STAT1) |-> (reg_rdata[S1_CARD_LVL] == card_present));

endmodule

// File: tb/test_sdirq_status_bank.sv
`timescale 1ns/1ps
module test_sdirq_status_bank;

  localparam logic [15:0] EV1 = 16'h001D;
  localparam logic [15:0] EV2 = 16'h837F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rsp_done_p, data_done_p, card_removed_p, card_inserted_p;
  logic        cmd_idx_err_p, crc_err_p, end_bit_err_p, data_tmo_p;
  logic        ill_wr_p, ill_rd_p, rsp_tmo_p, ill_acc_p;
  logic        rd_buf_rdy, wr_buf_rdy, card_present, dat0_lvl, cmd_busy;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;

  logic [15:0] e1 = '0, e2 = '0, m1 = EV1, m2 = EV2;
  logic        rdl = 1'b0, wrl = 1'b0, prd = 1'b0, pwr = 1'b0;

  always #4 clk = ~clk;

  sdirq_status_bank i_sdirq_status_bank (
    .clk(clk), .rst_n(rst_n),
    .rsp_done_p(rsp_done_p), .data_done_p(data_done_p),
    .card_removed_p(card_removed_p), .card_inserted_p(card_inserted_p),
    .cmd_idx_err_p(cmd_idx_err_p), .crc_err_p(crc_err_p),
    .end_bit_err_p(end_bit_err_p), .data_tmo_p(data_tmo_p),
    .ill_wr_p(ill_wr_p), .ill_rd_p(ill_rd_p), .rsp_tmo_p(rsp_tmo_p),
    .ill_acc_p(ill_acc_p), .rd_buf_rdy(rd_buf_rdy), .wr_buf_rdy(wr_buf_rdy),
    .card_present(card_present), .dat0_lvl(dat0_lvl), .cmd_busy(cmd_busy),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_pulses(input logic [15:0] s1, input logic [15:0] s2);
    rsp_done_p = s1[0];  data_done_p = s1[2];
    card_removed_p = s1[3]; card_inserted_p = s1[4];
    cmd_idx_err_p = s2[0]; crc_err_p = s2[1]; end_bit_err_p = s2[2];
    data_tmo_p = s2[3]; ill_wr_p = s2[4]; ill_rd_p = s2[5];
    rsp_tmo_p = s2[6]; ill_acc_p = s2[15];
  endtask

  // one clock: pulses, buffer levels and optional write; model follows
  task automatic step(input logic [15:0] s1, input logic [15:0] s2,
                      input logic we, input logic [1:0] a, input logic [15:0] wd);
    logic [15:0] k1, k2, rs;
    @(negedge clk);
    drive_pulses(s1, s2);
    rd_buf_rdy = rdl; wr_buf_rdy = wrl;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    rs = '0;
    rs[8] = rdl & ~prd;
    rs[9] = wrl & ~pwr;
    prd = rdl; pwr = wrl;
    k1 = (we && a == 2'd0) ? wd : 16'hFFFF;
    k2 = (we && a == 2'd1) ? wd : 16'hFFFF;
    e1 = ((e1 & k1) | s1) & EV1;
    e2 = ((e2 & k2) | (s2 & ~16'h0300) | rs) & EV2;
    if (we && a == 2'd2) m1 = wd & EV1;
    if (we && a == 2'd3) m2 = wd & EV2;
    @(posedge clk);
    #2;
    drive_pulses('0, '0);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic chk_all(input string tag);
    logic [15:0] d;
    logic [15:0] x1, x2;
    x1 = e1 | (16'(card_present) << 5);
    x2 = e2 | (16'(dat0_lvl) << 7) | (16'(cmd_busy) << 14);
    rd(2'd0, d); chk({tag, " stat1"}, d, x1);
    rd(2'd1, d); chk({tag, " stat2"}, d, x2);
    rd(2'd2, d); chk({tag, " mask1"}, d, m1);
    rd(2'd3, d); chk({tag, " mask2"}, d, m2);
    chk({tag, " irq"}, 16'(irq), 16'(|(e1 & ~m1) | |(e2 & ~m2)));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    drive_pulses('0, '0);
    rd_buf_rdy = 0; wr_buf_rdy = 0; card_present = 0; dat0_lvl = 0; cmd_busy = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #2 chk_all("R1 reset");

    // every event bit of both registers: set, irq, write-one, clear (R2 R4 R7 R10)
    for (int bank = 0; bank < 2; bank++) begin
      for (int b = 0; b < 16; b++) begin
        logic [15:0] bit_v, ev;
        bit_v = 16'(1) << b;
        ev = (bank == 0) ? EV1 : (EV2 & ~16'h0300);
        if ((ev & bit_v) == 0) continue;
        if (bank == 0) begin step(bit_v, '0, 0, 0, 0); chk_all("R2 set"); end
        else begin step('0, bit_v, 0, 0, 0); chk_all("R4 set"); end
        step('0, '0, 1, 2'(bank + 2), ~bit_v); chk_all("R10 unmasked");
        step('0, '0, 1, 2'(bank), 16'hFFFF); chk_all("R7 write one");
        step('0, '0, 1, 2'(bank), ~bit_v); chk_all("R7 write zero");
        step('0, '0, 1, 2'(bank + 2), 16'hFFFF); chk_all("R9 remask");
      end
    end

    // live levels ignore writes (R3 R5), idle bits read zero (R11)
    card_present = 1; dat0_lvl = 1; cmd_busy = 1;
    step('0, '0, 1, 0, 16'h0000); chk_all("R3 live write0");
    step('0, '0, 1, 1, 16'h0000); chk_all("R5 live write0");
    card_present = 0; dat0_lvl = 0; cmd_busy = 1;
    step('0, '0, 1, 0, 16'hFFFF); chk_all("R3 live write1");
    step('0, '0, 1, 1, 16'hFFFF); chk_all("R5 live write1");
    step(16'hFFFF, 16'hFFFF, 0, 0, 0); chk_all("R11 unused bits");
    step('0, '0, 1, 0, 0); step('0, '0, 1, 1, 0); chk_all("R7 all clear");

    // buffer-ready edges (R6)
    rdl = 1; step('0, '0, 0, 0, 0); chk_all("R6 rd edge");
    step('0, '0, 1, 1, ~16'h0100); chk_all("R6 rd clear");
    repeat (4) step('0, '0, 0, 0, 0);
    chk_all("R6 rd no retrigger");
    wrl = 1; step('0, '0, 0, 0, 0); chk_all("R6 wr edge");
    step('0, '0, 1, 1, 16'h0000); repeat (3) step('0, '0, 0, 0, 0);
    chk_all("R6 both held");
    rdl = 0; wrl = 0; step('0, '0, 0, 0, 0);
    rdl = 1; wrl = 1; step('0, '0, 0, 0, 0); chk_all("R6 re-edge");
    rdl = 0; wrl = 0;
    step('0, '0, 1, 1, 0);

    // event wins over a simultaneous clear (R8)
    step(16'h0001, 16'h0008, 0, 0, 0);
    step(16'h0004, '0, 1, 0, 16'h0000); chk_all("R8 stat1 race");
    step('0, 16'h0008, 1, 1, 16'h0000); chk_all("R8 stat2 race");

    // mask readback (R9)
    step('0, '0, 1, 2, 16'h0000); step('0, '0, 1, 3, 16'hFFFF); chk_all("R9 masks");
    step('0, '0, 1, 3, 16'h5A5A); chk_all("R9 mask2 pattern");

    // pseudo-random sweep against the model (R10 R8 R6 R7)
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic [15:0] s1, s2, wd;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s1 = (lf[3:0] == 0) ? (lf & EV1) : '0;
      s2 = (lf[7:4] == 0) ? ({lf[7:0], lf[15:8]} & EV2) : '0;
      rdl = lf[9] & lf[2]; wrl = lf[11] & lf[6];
      card_present = lf[12]; dat0_lvl = lf[1]; cmd_busy = lf[14];
      wd = {lf[7:0], lf[15:8]} ^ 16'h3C3C;
      step(s1, s2, lf[5] | lf[8], lf[13:12], wd);
      chk_all("R10 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule